// File: doc/BRIEF.md
# Multi-Channel Edge-Placed PWM Generator

This block drives a configurable number of PWM outputs, up to sixteen, from one shared timebase. An 8-bit prescaler divides the clock, and an 8-bit step counter then walks through the period. Each channel does not hold a duty-cycle value. It holds two 8-bit step positions instead: one where its output goes high and one where it goes low. Software sets these positions by byte-addressed writes through a plain register port. It reads them back through the same port.

Any subset of channels can be given shadow copies of its two position registers, chosen by an elaboration mask. Writes to a shadowed channel are held back. They are moved into the working registers together, at the first period boundary after software requests a commit, so a waveform never shows a half-updated mix of old and new edges. Channels without shadows take a write at once. When any channel is shadowed, the prescale and period registers are shadowed as well.

Top module: `pwmEdgeGen`

## Requirements
- R1: After reset every output is low, every register reads 0, and the prescaler and step counter are both 0.
- R2: The step counter advances by one each time the prescaler passes its last count (the prescale value). It returns to 0 after its last count (the period value). A full period is therefore (prescale+1)·(period+1) clocks, and the counter never skips a value.
- R3: Byte addresses are: prescale 0x00, period 0x04, lower enables 0x08 (bit n is channel n), upper enables 0x0C (bit n is channel n+8), commit request 0xE4. Channel i has its high position at 0x10+8·i and its low position at 0x14+8·i. Enable bits of channels that do not exist read 0.
- R4: A channel is evaluated only in the first clock of each step. If the step count equals its high position, the output is high from the next clock. If it equals its low position, the output is low from the next clock. Between evaluations the output holds.
- R5: When the high and low positions are equal, the output inverts at that step in every period. This gives a square wave of twice the programmed period.
- R6: A position greater than the period value never matches. High position 0 with low position period+1 gives a constant high. High position period+1 with low position 0 gives a constant low.
- R7: A channel whose enable bit is 0 drives low from the clock after the bit is seen clear.
- R8: A write to a channel without shadows changes its working register at once, mid-period included. Readback shows the new value straight away.
- R9: For a shadowed channel, a write goes only to the shadow copy. Writing 1 in bit 0 of 0xE4 arms a commit. The copy moves to the working registers at the end of the last clock of the period then running. Readback returns the working value, so the new value appears only after that boundary. With the reset configuration every clock is a boundary, so the commit lands one clock after the request.
- R10: When any channel is shadowed, prescale and period are shadowed too and are committed with the channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe for one clock |
| busAddr | input | 8 | Byte address for writes and reads |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| pwmOut | output | NUM_CH | PWM outputs, one per channel |

## Verification
A slip in the step counter or the prescaler changes the phase of every enabled output at its next evaluation. The error therefore shows within one period on all channels together. A wrong working or shadow register shows up in two places. Readback disagrees at once, and the affected output departs from the arithmetic model at the next step where the position falls. A commit that fires early or late shows up in readback around the boundary. It also shows as a shift of the shadowed channel's edge in the following period, while the unshadowed channels stay correct.

// File: rtl/pwmEdgePkg.sv
package pwmEdgePkg;
  localparam int REG_W = 8;
  localparam int ADDR_W = 8;
  localparam int MAX_CH = 16;
  localparam int CH_IDX_W = $clog2(MAX_CH);
  localparam int SLOT_W = ADDR_W - 3;

  localparam logic [ADDR_W-1:0] ADDR_PRESCALE = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 8'h04;
  localparam logic [ADDR_W-1:0] ADDR_EN_LO = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_EN_HI = 8'h0C;
  localparam logic [ADDR_W-1:0] ADDR_EDGE_BASE = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_COMMIT = 8'hE4;

  typedef enum logic [2:0] {
    RD_NONE, RD_PRE, RD_PER, RD_EN_LO, RD_EN_HI, RD_RISE, RD_FALL
  } rdKindT;

  typedef struct packed {
    logic              wrPre;
    logic              wrPer;
    logic              wrEnLo;
    logic              wrEnHi;
    logic [MAX_CH-1:0] wrRise;
    logic [MAX_CH-1:0] wrFall;
    logic [REG_W-1:0]  wrData;
    logic              commit;
    logic              step;
    logic [REG_W-1:0]  stepCount;
    rdKindT            rdKind;
    logic [CH_IDX_W-1:0] rdCh;
  } ctrlStrobeT;
endpackage

// File: rtl/pwmEdgeCtrl.sv
module pwmEdgeCtrl
  import pwmEdgePkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic [REG_W-1:0]  activePre,
  input  logic [REG_W-1:0]  activePer,
  output ctrlStrobeT        strobes
);
  localparam logic [SLOT_W-1:0] SLOT_BASE = ADDR_EDGE_BASE[ADDR_W-1:3];
  localparam logic [SLOT_W-1:0] CH_LIMIT = SLOT_W'(NUM_CH);

  logic [REG_W-1:0] preCnt;
  logic [REG_W-1:0] perCnt;
  logic syncPending;
  logic atWrap;
  logic atBoundary;
  logic commitNow;
  logic commitReq;
  logic [SLOT_W-1:0] chSlot;
  logic edgeHit;
  logic isFall;

  assign atWrap = (preCnt == activePre);
  assign atBoundary = atWrap && (perCnt == activePer);
  assign commitNow = syncPending && atBoundary;
  assign commitReq = busWrite && (busAddr == ADDR_COMMIT) && busWdata[0];

  // Channel decode: slot = addr/8, channel = slot - 2, word 0 = high, word 4 = low
  assign chSlot = busAddr[ADDR_W-1:3] - SLOT_BASE;
  assign edgeHit = (busAddr[1:0] == 2'b00) && (chSlot < CH_LIMIT);
  assign isFall = busAddr[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      perCnt <= '0;
      syncPending <= 1'b0;
    end else begin
      if (atWrap) begin
        preCnt <= '0;
        perCnt <= atBoundary ? '0 : perCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
      syncPending <= (syncPending && !commitNow) || commitReq;
    end
  end

  always_comb begin
    strobes = '0;
    strobes.wrData = busWdata;
    strobes.wrPre = busWrite && (busAddr == ADDR_PRESCALE);
    strobes.wrPer = busWrite && (busAddr == ADDR_PERIOD);
    strobes.wrEnLo = busWrite && (busAddr == ADDR_EN_LO);
    strobes.wrEnHi = busWrite && (busAddr == ADDR_EN_HI);
    for (int c = 0; c < NUM_CH; c++) begin
      strobes.wrRise[c] = busWrite && edgeHit && !isFall && (chSlot == SLOT_W'(c));
      strobes.wrFall[c] = busWrite && edgeHit && isFall && (chSlot == SLOT_W'(c));
    end
    strobes.commit = commitNow;
    strobes.step = (preCnt == '0);
    strobes.stepCount = perCnt;
    strobes.rdCh = chSlot[CH_IDX_W-1:0];
    if (busAddr == ADDR_PRESCALE) strobes.rdKind = RD_PRE;
    else if (busAddr == ADDR_PERIOD) strobes.rdKind = RD_PER;
    else if (busAddr == ADDR_EN_LO) strobes.rdKind = RD_EN_LO;
    else if (busAddr == ADDR_EN_HI) strobes.rdKind = RD_EN_HI;
    else if (edgeHit) strobes.rdKind = isFall ? RD_FALL : RD_RISE;
    else strobes.rdKind = RD_NONE;
  end
endmodule

// File: rtl/pwmEdgeDatapath.sv
module pwmEdgeDatapath
  import pwmEdgePkg::*;
#(
  parameter int NUM_CH = 16,
  parameter logic [MAX_CH-1:0] SHADOW_MASK = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  output logic [REG_W-1:0]  activePre,
  output logic [REG_W-1:0]  activePer,
  output logic [MAX_CH-1:0] enBits,
  output logic [REG_W-1:0]  rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  localparam logic [MAX_CH-1:0] CH_MASK = MAX_CH'((32'd1 << NUM_CH) - 32'd1);
  localparam bit TB_SHADOW = |(SHADOW_MASK & CH_MASK);

  logic [REG_W-1:0] enLo;
  logic [REG_W-1:0] enHi;
  logic [REG_W-1:0] riseVec [NUM_CH];
  logic [REG_W-1:0] fallVec [NUM_CH];

  assign enBits = {enHi, enLo} & CH_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enLo <= '0;
      enHi <= '0;
    end else begin
      if (strobes.wrEnLo) enLo <= strobes.wrData;
      if (strobes.wrEnHi) enHi <= strobes.wrData;
    end
  end

  // Timebase limits: shadowed together with the channels when any channel is
  if (TB_SHADOW) begin : gTbShadow
    logic [REG_W-1:0] shPre;
    logic [REG_W-1:0] shPer;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shPre <= '0;
        shPer <= '0;
        activePre <= '0;
        activePer <= '0;
      end else begin
        if (strobes.wrPre) shPre <= strobes.wrData;
        if (strobes.wrPer) shPer <= strobes.wrData;
        if (strobes.commit) begin
          activePre <= shPre;
          activePer <= shPer;
        end
      end
    end
  end else begin : gTbDirect
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        activePre <= '0;
        activePer <= '0;
      end else begin
        if (strobes.wrPre) activePre <= strobes.wrData;
        if (strobes.wrPer) activePer <= strobes.wrData;
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : gChan
    logic [REG_W-1:0] riseQ;
    logic [REG_W-1:0] fallQ;
    logic outQ;

    if (SHADOW_MASK[i]) begin : gShadow
      logic [REG_W-1:0] riseSh;
      logic [REG_W-1:0] fallSh;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          riseSh <= '0;
          fallSh <= '0;
          riseQ <= '0;
          fallQ <= '0;
        end else begin
          if (strobes.wrRise[i]) riseSh <= strobes.wrData;
          if (strobes.wrFall[i]) fallSh <= strobes.wrData;
          if (strobes.commit) begin
            riseQ <= riseSh;
            fallQ <= fallSh;
          end
        end
      end
    end else begin : gDirect
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          riseQ <= '0;
          fallQ <= '0;
        end else begin
          if (strobes.wrRise[i]) riseQ <= strobes.wrData;
          if (strobes.wrFall[i]) fallQ <= strobes.wrData;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outQ <= 1'b0;
      end else if (!enBits[i]) begin
        outQ <= 1'b0;
      end else if (strobes.step) begin
        if (riseQ == fallQ) begin
          if (strobes.stepCount == riseQ) outQ <= ~outQ;
        end else if (strobes.stepCount == riseQ) begin
          outQ <= 1'b1;
        end else if (strobes.stepCount == fallQ) begin
          outQ <= 1'b0;
        end
      end
    end

    assign riseVec[i] = riseQ;
    assign fallVec[i] = fallQ;
    assign pwmOut[i] = outQ;
  end

  always_comb begin
    case (strobes.rdKind)
      RD_PRE:   rdData = activePre;
      RD_PER:   rdData = activePer;
      RD_EN_LO: rdData = enBits[REG_W-1:0];
      RD_EN_HI: rdData = enBits[MAX_CH-1:REG_W];
      RD_RISE:  rdData = riseVec[strobes.rdCh];
      RD_FALL:  rdData = fallVec[strobes.rdCh];
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/pwmEdgeGen.sv
module pwmEdgeGen
  import pwmEdgePkg::*;
#(
  parameter int NUM_CH = 16,
  parameter logic [MAX_CH-1:0] SHADOW_MASK = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  output logic [NUM_CH-1:0] pwmOut
);
  ctrlStrobeT strobes;
  logic [REG_W-1:0] activePre;
  logic [REG_W-1:0] activePer;
  logic [MAX_CH-1:0] enBits;

  pwmEdgeCtrl #(.NUM_CH(NUM_CH)) uCtrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .activePre(activePre), .activePer(activePer),
    .strobes(strobes)
  );

  pwmEdgeDatapath #(.NUM_CH(NUM_CH), .SHADOW_MASK(SHADOW_MASK)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .activePre(activePre),
    .activePer(activePer), .enBits(enBits), .rdData(busRdata), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwmEdgeChecker.sv
module pwmEdgeChecker
  import pwmEdgePkg::*;
#(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] pwmOut,
  input logic [MAX_CH-1:0] enBits,
  input ctrlStrobeT        strobes
);
  // R2: step count only advances by one or wraps to zero
  assert_count_no_skip_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |-> (strobes.stepCount == '0) ||
                     (strobes.stepCount == $past(strobes.stepCount) + 1'b1));

  // R9: a commit always lands on a period boundary
  assert_commit_on_boundary_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> (strobes.step && strobes.stepCount == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : gChk
    // R7: disabled channel drives low
    assert_disabled_low_R7: assert property (@(posedge clk) disable iff (!rstN)
      !enBits[i] |=> !pwmOut[i]);
    // R4: output holds between step evaluations
    assert_hold_between_steps_R4: assert property (@(posedge clk) disable iff (!rstN)
      (enBits[i] && !strobes.step) |=> $stable(pwmOut[i]));
  end
endmodule

bind pwmEdgeGen pwmEdgeChecker #(.NUM_CH(NUM_CH)) uChk (
  .clk(clk), .rstN(rstN), .pwmOut(pwmOut), .enBits(enBits), .strobes(strobes)
);

// File: tb/pwmEdgeGen_bench.sv
module pwmEdgeGen_bench;
  localparam int NCH = 10;
  localparam logic [15:0] SMASK = 16'h020C;
  localparam int HUGE = 1 << 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrite = 1'b0;
  logic [7:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [NCH-1:0] pwmOut;

  pwmEdgeGen #(.NUM_CH(NCH), .SHADOW_MASK(SMASK)) u_pwmEdgeGen (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  int P, Q, C0;
  int rOld[NCH], fOld[NCH], rNew[NCH], enCyc[NCH], disCyc[NCH], swCyc[NCH];

  task automatic check(input string req, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int expOut(int ch, int m);
    int st;
    st = 0;
    if (m > disCyc[ch] || m <= enCyc[ch]) return 0;
    for (int n = enCyc[ch]; n < m; n++) begin
      int rel, c, r, f;
      rel = n - C0;
      if (rel % P == 0) begin
        c = (rel / P) % Q;
        r = (n >= swCyc[ch]) ? rNew[ch] : rOld[ch];
        f = fOld[ch];
        if (r == f) begin
          if (c == r) st = 1 - st;
        end else if (c == r) st = 1;
        else if (c == f) st = 0;
      end
    end
    return st;
  endfunction

  function automatic string chReq(int ch, int m);
    if (m > disCyc[ch]) return "R7";
    case (ch % 5)
      0: return "R2";
      1: return "R5";
      2: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output int e);
    @(negedge clk);
    busWrite = 1'b1;
    busAddr = a;
    busWdata = d;
    e = cyc + 1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input int exp);
    @(negedge clk);
    busAddr = a;
    #1;
    check(req, busRdata, exp);
  endtask

  task automatic runChk(input int n);
    repeat (n) begin
      @(negedge clk);
      for (int ch = 0; ch < NCH; ch++)
        check(chReq(ch, cyc), pwmOut[ch], expOut(ch, cyc));
    end
  endtask

  task automatic runConfig(input int pre, input int per);
    int e, s;
    int b;
    // R1: reset state
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1", pwmOut, 0);
    rdChk("R1", 8'h00, 0);
    rdChk("R1", 8'h04, 0);
    rdChk("R1", 8'h08, 0);
    rdChk("R1", 8'h0C, 0);
    for (int ch = 0; ch < NCH; ch++) begin
      rdChk("R1", 8'(8'h10 + 8 * ch), 0);
      rdChk("R1", 8'(8'h14 + 8 * ch), 0);
    end

    P = pre + 1;
    Q = per + 1;
    for (int ch = 0; ch < NCH; ch++) begin
      case (ch % 5)
        0: begin rOld[ch] = 0; fOld[ch] = Q / 2; end
        1: begin rOld[ch] = per; fOld[ch] = per; end
        2: begin rOld[ch] = per; fOld[ch] = 0; end
        3: begin rOld[ch] = 0; fOld[ch] = Q; end
        default: begin rOld[ch] = Q; fOld[ch] = 0; end
      endcase
      rNew[ch] = rOld[ch];
      swCyc[ch] = HUGE;
      disCyc[ch] = HUGE;
      enCyc[ch] = HUGE;
    end

    wr(8'h00, 8'(pre), e);
    wr(8'h04, 8'(per), e);
    for (int ch = 0; ch < NCH; ch++) begin
      wr(8'(8'h10 + 8 * ch), 8'(rOld[ch]), e);
      wr(8'(8'h14 + 8 * ch), 8'(fOld[ch]), e);
    end
    // R10: timebase shadowed, R9: shadowed channels still 0, R8/R3: direct ones updated
    rdChk("R10", 8'h00, 0);
    rdChk("R10", 8'h04, 0);
    for (int ch = 0; ch < NCH; ch++) begin
      if (SMASK[ch]) begin
        rdChk("R9", 8'(8'h10 + 8 * ch), 0);
        rdChk("R9", 8'(8'h14 + 8 * ch), 0);
      end else begin
        rdChk("R8", 8'(8'h10 + 8 * ch), rOld[ch]);
        rdChk("R3", 8'(8'h14 + 8 * ch), fOld[ch]);
      end
    end

    wr(8'hE4, 8'h01, s);
    C0 = s + 1;  // reset config: every clock is a boundary
    rdChk("R10", 8'h00, pre);
    rdChk("R10", 8'h04, per);
    rdChk("R9", 8'h10 + 8 * 2, rOld[2]);
    rdChk("R9", 8'h14 + 8 * 9, fOld[9]);

    wr(8'h08, 8'hFF, e);
    for (int ch = 0; ch < 8; ch++) enCyc[ch] = e;
    wr(8'h0C, 8'hFF, e);
    for (int ch = 8; ch < NCH; ch++) enCyc[ch] = e;
    rdChk("R3", 8'h08, 8'hFF);
    rdChk("R3", 8'h0C, 8'h03);
    runChk(3 * P * Q + 6);

    // R8: direct write mid-period
    rNew[0] = (rOld[0] + 1) % (Q + 1);
    wr(8'h10, 8'(rNew[0]), e);
    swCyc[0] = e;
    rdChk("R8", 8'h10, rNew[0]);
    // R9: shadowed write held until commit
    rNew[2] = (rOld[2] + 1) % (Q + 1);
    wr(8'h20, 8'(rNew[2]), e);
    rdChk("R9", 8'h20, rOld[2]);
    runChk(P * Q + 2);
    rdChk("R9", 8'h20, rOld[2]);
    wr(8'hE4, 8'h01, s);
    b = s;
    while ((b - C0) % (P * Q) != P * Q - 1) b++;
    swCyc[2] = b + 1;
    runChk(2 * P * Q + 4);
    rdChk("R9", 8'h20, rNew[2]);

    // R7: disable lower channels, upper keep running
    wr(8'h08, 8'h00, e);
    for (int ch = 0; ch < 8; ch++) disCyc[ch] = e;
    runChk(2 * P * Q + 4);
    rdChk("R7", 8'h08, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    runConfig(1, 4);
    runConfig(0, 3);
    runConfig(2, 2);
    runConfig(3, 1);
    runConfig(0, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule